// File: doc/BRIEF.md
# Fault Event Log Recorder

The recorder turns qualified fault events and configuration changes into fixed-format log records. Each record is stored in a small record queue that a host or storage controller drains. Records can be put in a total order without a real-time clock. The ordering key combines three values: a power-up counter, a monotonic sequence number and a millisecond count since boot. Every record leaves the recorder marked unsynced. A bulk-commit handshake from the consumer marks the records still queued as committed.

Two mechanisms limit write amplification. First, events flagged as in-band fluctuations near a threshold are only counted: every `BAND_N`-th such hit produces one summary record. Second, a configuration write produces a record only when it changes the stored filter snapshot of its rail. When the queue is full, a record is dropped and a drop counter increments. The sequence number still advances, so the consumer sees the gap.

The control state machine has three states:
- BOOT lasts for the first cycle after reset and increments the power-up counter. Transition BOOT→RUN is taken unconditionally.
- RUN is the normal recording state. Transition RUN→COMMIT is taken on `commit_req`.
- COMMIT lasts one cycle, raises the acknowledge and marks queued records committed. Transition COMMIT→RUN is taken unconditionally.

Top module: `evlog_recorder`

## Requirements
- R1: During reset the power-up counter loads `boot_in`. In the BOOT cycle it becomes `boot_in+1`, wrapping at 16 bits. It then holds that value, and every record carries it.
- R2: The sequence counter is 0 after reset. Each record attempt, whether stored or dropped, takes the current value and then increments it by one, wrapping from 65535 to 0.
- R3: The 32-bit timestamp is 0 after reset and increments once for each cycle in which `ms_tick` is high. A record carries the value held before the edge at which the record is formed.
- R4: An event with `ev_valid=1` and `ev_in_band=0` forms one record. The record carries the event's rail, class, code and route, the current 16-bit filter snapshot of that rail, and sync flag 0 (unsynced).
- R5: Events with `ev_valid=1` and `ev_in_band=1` only advance the band counter. On every `BAND_N`-th such hit, one summary record is formed. It has class 8'h0A, code `BAND_N`, the event's rail and route, and the rail's snapshot. The other hits form no record and take no sequence number.
- R6: A `cfg_wr` whose value differs from the rail's snapshot updates the snapshot. It forms one record with class 8'h09, code equal to the old snapshot, snapshot field equal to the new value, and route 0. A write of the value already held forms no record and takes no sequence number. Snapshots are 0 after reset.
- R7: A `cfg_wr` in the same cycle as `ev_valid` is ignored entirely. The snapshot keeps its old value.
- R8: When the queue holds `DEPTH` records, a new record is dropped and `drop_cnt` increments. The queued records are unchanged.
- R9: `commit_req` seen in RUN raises `commit_ack` for exactly the next cycle. At the end of that cycle, every record then queued reads sync flag 1. A record formed during the acknowledge cycle stays 0.
- R10: Records leave in the order they were formed. The head record is presented while `rec_valid` is high and is removed on `rec_valid && rec_ready`.
- R11: Event and configuration inputs in the BOOT cycle are ignored.
- R12: Class codes used by sources are UV=1, OV=2, OC=3, OT=4, UT=5, ΔV=6, ΔI=7 and PG=8. Fault records pass them through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_in | input | 16 | Power-up count retained from the previous run |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| commit_req | input | 1 | Bulk-commit request from the consumer |
| ev_valid | input | 1 | Qualified fault event present |
| ev_in_band | input | 1 | Event is an in-band fluctuation |
| ev_rail | input | RAIL_W | Rail index of the event |
| ev_class | input | 8 | Event class code |
| ev_code | input | 16 | Raw sample code |
| ev_route | input | 8 | Route code of the event |
| cfg_wr | input | 1 | Filter-configuration write strobe |
| cfg_rail | input | RAIL_W | Rail whose snapshot is written |
| cfg_value | input | 16 | New filter-configuration snapshot |
| rec_ready | input | 1 | Consumer takes the head record |
| rec_valid | output | 1 | A record is queued |
| rec_boot | output | 16 | Power-up count of the head record |
| rec_seq | output | 16 | Sequence number of the head record |
| rec_ts | output | 32 | Millisecond timestamp of the head record |
| rec_rail | output | 8 | Rail index of the head record |
| rec_class | output | 8 | Class code of the head record |
| rec_code | output | 16 | Raw or summary code of the head record |
| rec_snap | output | 16 | Filter snapshot of the head record |
| rec_route | output | 8 | Route code of the head record |
| rec_sync | output | 1 | 0 unsynced, 1 committed |
| commit_ack | output | 1 | Commit acknowledge pulse |
| drop_cnt | output | 16 | Number of dropped records |

## Verification
A corrupted sequence or timestamp register shows up in the very next record read at the head: the ordering key either skips or repeats. A band counter off by one shifts the summary record by a hit. This is visible within `BAND_N` hits, as a record appearing early or missing. A stale snapshot register appears in the `rec_snap` field of the next fault record on that rail, or as a missing configuration record. Errors in the sync flag and the queue pointers appear within one commit handshake, or after one pass through a full queue, as a wrong flag or an out-of-order sequence.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
    localparam int BOOT_W = 16;
    localparam int SEQ_W  = 16;
    localparam int TS_W   = 32;
    localparam int CODE_W = 16;
    localparam int SNAP_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CLS_CFG  = 8'h09;
    localparam logic [BYTE_W-1:0] CLS_BAND = 8'h0A;

    typedef struct packed {
        logic [BOOT_W-1:0] boot;
        logic [SEQ_W-1:0]  seq;
        logic [TS_W-1:0]   ts;
        logic [BYTE_W-1:0] rail;
        logic [BYTE_W-1:0] cls;
        logic [CODE_W-1:0] code;
        logic [SNAP_W-1:0] snap;
        logic [BYTE_W-1:0] route;
    } rec_t;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_COMMIT = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/evlog_fifo.sv
module evlog_fifo
    import evlog_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  rec_t push_rec,
    input  logic pop,
    input  logic commit,
    output rec_t head_rec,
    output logic head_sync,
    output logic empty,
    output logic full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rec_t             mem [DEPTH];
    logic [DEPTH-1:0] sync_q;
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             pop_ok;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));
    assign pop_ok    = pop && !empty;
    assign head_rec  = mem[rp_q];
    assign head_sync = sync_q[rp_q];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
        end else begin
            if (commit) sync_q <= '1;
            if (push) begin
                sync_q[wp_q] <= 1'b0;
                wp_q         <= nxt(wp_q);
            end
            if (pop_ok) rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);                                           // R8
    AST_NEW_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && empty) |=> !head_sync);                           // R4
    AST_COMMIT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !empty && !pop) |=> head_sync);                 // R9
endmodule

// File: rtl/evlog_source.sv
module evlog_source
    import evlog_pkg::*;
#(
    parameter int RAIL_W = 2,
    parameter int BAND_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ev_valid,
    input  logic              ev_in_band,
    input  logic [RAIL_W-1:0] ev_rail,
    input  logic [BYTE_W-1:0] ev_class,
    input  logic [CODE_W-1:0] ev_code,
    input  logic [BYTE_W-1:0] ev_route,
    input  logic              cfg_wr,
    input  logic [RAIL_W-1:0] cfg_rail,
    input  logic [SNAP_W-1:0] cfg_value,
    output logic              fire,
    output logic [BYTE_W-1:0] o_rail,
    output logic [BYTE_W-1:0] o_cls,
    output logic [CODE_W-1:0] o_code,
    output logic [SNAP_W-1:0] o_snap,
    output logic [BYTE_W-1:0] o_route
);
    localparam int NRAIL = 1 << RAIL_W;
    localparam int BCW   = $clog2(BAND_N + 1);

    logic [NRAIL-1:0][SNAP_W-1:0] snap_q;
    logic [BCW-1:0]               band_q;
    logic fault_hit, band_hit, band_last, cfg_take, cfg_diff;

    assign fault_hit = run && ev_valid && !ev_in_band;
    assign band_hit  = run && ev_valid && ev_in_band;
    assign band_last = band_hit && (band_q == BCW'(BAND_N - 1));
    assign cfg_take  = run && cfg_wr && !ev_valid;
    assign cfg_diff  = cfg_take && (snap_q[cfg_rail] != cfg_value);
    assign fire      = fault_hit || band_last || cfg_diff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            band_q <= '0;
        end else begin
            for (int r = 0; r < NRAIL; r++) begin
                if (cfg_take && (cfg_rail == RAIL_W'(r))) snap_q[r] <= cfg_value;
            end
            if (band_last)     band_q <= '0;
            else if (band_hit) band_q <= band_q + BCW'(1);
        end
    end

    always_comb begin
        o_rail  = {{(BYTE_W-RAIL_W){1'b0}}, ev_rail};
        o_cls   = ev_class;
        o_code  = ev_code;
        o_snap  = snap_q[ev_rail];
        o_route = ev_route;
        if (cfg_diff) begin
            o_rail  = {{(BYTE_W-RAIL_W){1'b0}}, cfg_rail};
            o_cls   = CLS_CFG;
            o_code  = snap_q[cfg_rail];
            o_snap  = cfg_value;
            o_route = '0;
        end else if (band_last) begin
            o_cls  = CLS_BAND;
            o_code = CODE_W'(BAND_N);
        end
    end

    AST_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && ev_valid) |=> $stable(snap_q));                 // R7
    AST_BAND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        band_q < BCW'(BAND_N));                                    // R5
endmodule

// File: rtl/evlog_recorder.sv
module evlog_recorder
    import evlog_pkg::*;
#(
    parameter int RAIL_W = 2,
    parameter int BAND_N = 4,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       boot_in,
    input  logic              ms_tick,
    input  logic              commit_req,
    input  logic              ev_valid,
    input  logic              ev_in_band,
    input  logic [RAIL_W-1:0] ev_rail,
    input  logic [7:0]        ev_class,
    input  logic [15:0]       ev_code,
    input  logic [7:0]        ev_route,
    input  logic              cfg_wr,
    input  logic [RAIL_W-1:0] cfg_rail,
    input  logic [15:0]       cfg_value,
    input  logic              rec_ready,
    output logic              rec_valid,
    output logic [15:0]       rec_boot,
    output logic [15:0]       rec_seq,
    output logic [31:0]       rec_ts,
    output logic [7:0]        rec_rail,
    output logic [7:0]        rec_class,
    output logic [15:0]       rec_code,
    output logic [15:0]       rec_snap,
    output logic [7:0]        rec_route,
    output logic              rec_sync,
    output logic              commit_ack,
    output logic [15:0]       drop_cnt
);
    ctl_state_t        state_q, state_d;
    logic [BOOT_W-1:0] boot_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [TS_W-1:0]   ts_q;
    logic [15:0]       drop_q;
    logic              run, fire, full, empty, do_commit;
    rec_t              new_rec, head;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_RUN;
            ST_RUN:    if (commit_req) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_RUN;
            default:   state_d = ST_BOOT;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run        = 1'b1;
        do_commit  = 1'b0;
        unique case (state_q)
            ST_BOOT:   run = 1'b0;
            ST_RUN:    ;
            ST_COMMIT: do_commit = 1'b1;
            default:   run = 1'b0;
        endcase
    end
    assign commit_ack = do_commit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= boot_in;
            seq_q  <= '0;
            ts_q   <= '0;
            drop_q <= '0;
        end else begin
            if (state_q == ST_BOOT) boot_q <= boot_q + BOOT_W'(1);
            if (ms_tick)            ts_q   <= ts_q + TS_W'(1);
            if (fire)               seq_q  <= seq_q + SEQ_W'(1);
            if (fire && full)       drop_q <= drop_q + 16'd1;
        end
    end

    evlog_source #(.RAIL_W(RAIL_W), .BAND_N(BAND_N)) u_src (
        .clk(clk), .rst_n(rst_n), .run(run),
        .ev_valid(ev_valid), .ev_in_band(ev_in_band), .ev_rail(ev_rail),
        .ev_class(ev_class), .ev_code(ev_code), .ev_route(ev_route),
        .cfg_wr(cfg_wr), .cfg_rail(cfg_rail), .cfg_value(cfg_value),
        .fire(fire), .o_rail(new_rec.rail), .o_cls(new_rec.cls),
        .o_code(new_rec.code), .o_snap(new_rec.snap), .o_route(new_rec.route)
    );

    assign new_rec.boot = boot_q;
    assign new_rec.seq  = seq_q;
    assign new_rec.ts   = ts_q;

    evlog_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fire && !full), .push_rec(new_rec),
        .pop(rec_ready), .commit(do_commit), .head_rec(head),
        .head_sync(rec_sync), .empty(empty), .full(full)
    );

    assign rec_valid = !empty;
    assign rec_boot  = head.boot;
    assign rec_seq   = head.seq;
    assign rec_ts    = head.ts;
    assign rec_rail  = head.rail;
    assign rec_class = head.cls;
    assign rec_code  = head.code;
    assign rec_snap  = head.snap;
    assign rec_route = head.route;
    assign drop_cnt  = drop_q;

    AST_BOOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BOOT) |=> $stable(boot_q));                 // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (seq_q == $past(seq_q) + SEQ_W'(1)));             // R2
    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(seq_q));                                 // R2
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && full) |=> (drop_q == $past(drop_q) + 16'd1));     // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ack |=> !commit_ack);                               // R9
    AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |-> !fire);                           // R11
endmodule

// File: tb/tb_evlog_recorder.sv
module tb_evlog_recorder;
    localparam int RAIL_W = 2;
    localparam int BAND_N = 4;
    localparam int DEPTH  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] boot_in = 16'hFFFF;
    logic ms_tick = 0, commit_req = 0, ev_valid = 0, ev_in_band = 0;
    logic [RAIL_W-1:0] ev_rail = '0, cfg_rail = '0;
    logic [7:0] ev_class = 0, ev_route = 0;
    logic [15:0] ev_code = 0, cfg_value = 0;
    logic cfg_wr = 0, rec_ready = 0;
    logic rec_valid, rec_sync, commit_ack;
    logic [15:0] rec_boot, rec_seq, rec_code, rec_snap, drop_cnt;
    logic [31:0] rec_ts;
    logic [7:0] rec_rail, rec_class, rec_route;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] exp_boot;

    always #10 clk = ~clk;

    evlog_recorder #(.RAIL_W(RAIL_W), .BAND_N(BAND_N), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .boot_in(boot_in), .ms_tick(ms_tick),
        .commit_req(commit_req), .ev_valid(ev_valid), .ev_in_band(ev_in_band),
        .ev_rail(ev_rail), .ev_class(ev_class), .ev_code(ev_code),
        .ev_route(ev_route), .cfg_wr(cfg_wr), .cfg_rail(cfg_rail),
        .cfg_value(cfg_value), .rec_ready(rec_ready), .rec_valid(rec_valid),
        .rec_boot(rec_boot), .rec_seq(rec_seq), .rec_ts(rec_ts),
        .rec_rail(rec_rail), .rec_class(rec_class), .rec_code(rec_code),
        .rec_snap(rec_snap), .rec_route(rec_route), .rec_sync(rec_sync),
        .commit_ack(commit_ack), .drop_cnt(drop_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] b);
        @(negedge clk);
        boot_in = b;
        rst_n = 0;
        cyc();
        cyc();
        rst_n = 1;
        // R11: event and config offered during the BOOT cycle
        ev_valid = 1; ev_class = 8'd2; cfg_wr = 1; cfg_value = 16'h0BAD;
        cyc();
        ev_valid = 0; cfg_wr = 0; cfg_value = 0;
        exp_boot = b + 16'd1;
    endtask

    task automatic fault(input logic [RAIL_W-1:0] r, input logic [7:0] c,
                         input logic [15:0] code, input logic [7:0] rt);
        ev_valid = 1; ev_in_band = 0; ev_rail = r; ev_class = c;
        ev_code = code; ev_route = rt;
        cyc();
        ev_valid = 0;
    endtask

    task automatic cfg(input logic [RAIL_W-1:0] r, input logic [15:0] v);
        cfg_wr = 1; cfg_rail = r; cfg_value = v;
        cyc();
        cfg_wr = 0;
    endtask

    task automatic pop();
        rec_ready = 1;
        cyc();
        rec_ready = 0;
    endtask

    task automatic head(input string tag, input logic [15:0] sq, input logic [31:0] ts,
                        input logic [7:0] rl, input logic [7:0] cl, input logic [15:0] cd,
                        input logic [15:0] sn, input logic [7:0] rt, input logic sy);
        chk({tag, " valid"}, 64'(rec_valid), 64'd1);
        chk({tag, " boot"},  64'(rec_boot), 64'(exp_boot));
        chk({tag, " seq"},   64'(rec_seq), 64'(sq));
        chk({tag, " ts"},    64'(rec_ts), 64'(ts));
        chk({tag, " rail"},  64'(rec_rail), 64'(rl));
        chk({tag, " class"}, 64'(rec_class), 64'(cl));
        chk({tag, " code"},  64'(rec_code), 64'(cd));
        chk({tag, " snap"},  64'(rec_snap), 64'(sn));
        chk({tag, " route"}, 64'(rec_route), 64'(rt));
        chk({tag, " sync"},  64'(rec_sync), 64'(sy));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(16'hFFFF);
        // R1 wrap of power-up counter, R11 boot-cycle inputs ignored
        chk("R1 boot after wrap", 64'(dut.rec_boot === rec_boot), 64'd1);
        chk("R11 no record from boot cycle", 64'(rec_valid), 64'd0);
        chk("R8 drop count at reset", 64'(drop_cnt), 64'd0);
        chk("R9 ack idle at reset", 64'(commit_ack), 64'd0);

        // R3 timestamp: three millisecond ticks
        for (int i = 0; i < 3; i++) begin ms_tick = 1; cyc(); ms_tick = 0; cyc(); end
        fault(2'd2, 8'd2, 16'h0123, 8'd1);
        head("R4 R12 R1 R3 fault", 16'd0, 32'd3, 8'd2, 8'd2, 16'h0123, 16'd0, 8'd1, 1'b0);
        pop();

        // R6 configuration change
        cfg(2'd1, 16'h0055);
        head("R6 cfg record", 16'd1, 32'd3, 8'd1, 8'h09, 16'd0, 16'h0055, 8'd0, 1'b0);
        pop();
        cfg(2'd1, 16'h0055);
        chk("R6 same value no record", 64'(rec_valid), 64'd0);
        ms_tick = 1; cyc(); ms_tick = 0;
        fault(2'd1, 8'd1, 16'h0007, 8'd2);
        head("R6 R2 snapshot carried", 16'd2, 32'd4, 8'd1, 8'd1, 16'h0007, 16'h0055, 8'd2, 1'b0);
        pop();

        // R5 band summary: two full rounds
        for (int round = 0; round < 2; round++) begin
            for (int h = 1; h <= BAND_N; h++) begin
                ev_valid = 1; ev_in_band = 1; ev_rail = 2'd3; ev_class = 8'd4;
                ev_code = 16'(h); ev_route = 8'd3;
                cyc();
                ev_valid = 0; ev_in_band = 0;
                if (h < BAND_N) chk("R5 hit without record", 64'(rec_valid), 64'd0);
            end
            head("R5 band summary", 16'(3 + round), 32'd4, 8'd3, 8'h0A, 16'(BAND_N),
                 16'd0, 8'd3, 1'b0);
            pop();
        end

        // R7 coincident config write ignored
        ev_valid = 1; ev_rail = 2'd0; ev_class = 8'd3; ev_code = 16'h0AAA; ev_route = 8'd1;
        cfg_wr = 1; cfg_rail = 2'd0; cfg_value = 16'h0077;
        cyc();
        ev_valid = 0; cfg_wr = 0;
        head("R7 event wins", 16'd5, 32'd4, 8'd0, 8'd3, 16'h0AAA, 16'd0, 8'd1, 1'b0);
        pop();
        chk("R7 only one record", 64'(rec_valid), 64'd0);
        cfg(2'd0, 16'h0077);
        head("R7 snapshot kept old value", 16'd6, 32'd4, 8'd0, 8'h09, 16'd0, 16'h0077, 8'd0, 1'b0);
        pop();

        // R9 commit handshake
        fault(2'd0, 8'd6, 16'd10, 8'd0);
        fault(2'd1, 8'd7, 16'd11, 8'd0);
        chk("R9 unsynced before commit", 64'(rec_sync), 64'd0);
        commit_req = 1; cyc(); commit_req = 0;
        chk("R9 ack raised", 64'(commit_ack), 64'd1);
        ev_valid = 1; ev_rail = 2'd2; ev_class = 8'd8; ev_code = 16'd12; ev_route = 8'd0;
        cyc();
        ev_valid = 0;
        chk("R9 ack single cycle", 64'(commit_ack), 64'd0);
        head("R9 committed first", 16'd7, 32'd4, 8'd0, 8'd6, 16'd10, 16'h0077, 8'd0, 1'b1);
        pop();
        head("R9 committed second", 16'd8, 32'd4, 8'd1, 8'd7, 16'd11, 16'h0055, 8'd0, 1'b1);
        pop();
        head("R9 late record unsynced", 16'd9, 32'd4, 8'd2, 8'd8, 16'd12, 16'd0, 8'd0, 1'b0);
        pop();

        // R8 full queue drop with sequence gap, R10 order
        for (int i = 0; i < DEPTH + 1; i++) fault(2'd0, 8'd5, 16'(100 + i), 8'd0);
        chk("R8 drop counted", 64'(drop_cnt), 64'd1);
        for (int i = 0; i < DEPTH; i++) begin
            head("R10 R8 queued order", 16'(10 + i), 32'd4, 8'd0, 8'd5, 16'(100 + i),
                 16'h0077, 8'd0, 1'b0);
            pop();
        end
        chk("R8 dropped record absent", 64'(rec_valid), 64'd0);
        fault(2'd0, 8'd5, 16'd200, 8'd0);
        chk("R8 R2 sequence gap visible", 64'(rec_seq), 64'd15);
        pop();

        // R1 second power-up, R2 wrap through drops
        do_reset(16'd5);
        chk("R1 boot incremented", 64'(rec_valid), 64'd0);
        for (int i = 0; i < DEPTH; i++) fault(2'd1, 8'd1, 16'(i), 8'd0);
        chk("R1 boot carried", 64'(rec_boot), 64'd6);
        ev_valid = 1; ev_in_band = 0; ev_rail = 2'd1; ev_class = 8'd1; ev_code = 16'hFFFF;
        repeat (65536 - DEPTH) @(posedge clk);
        @(negedge clk);
        ev_valid = 0;
        chk("R8 drops during wrap run", 64'(drop_cnt), 64'(65536 - DEPTH));
        pop();
        fault(2'd1, 8'd1, 16'h0042, 8'd0);
        for (int i = 1; i < DEPTH; i++) begin
            chk("R2 R10 pre-wrap order", 64'(rec_seq), 64'(i));
            pop();
        end
        head("R2 sequence wrapped", 16'd0, 32'd0, 8'd1, 8'd1, 16'h0042, 16'd0, 8'd0, 1'b0);
        pop();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule